// File: doc/BRIEF.md
# Periodic Scrub Scheduler with Busy Handshake

This block decides when a protected memory gives up a cycle to scrub one word. It has two modes. In master mode a free-running interval timer raises a request every `2^n + 4` clocks, where `n` is a 4-bit period code. Each request starts a handshake. The active-low busy output drops first. A programmable number of clocks later the active-low scrub strobe drops. The strobe stays low for a fixed four clocks and then rises. Busy rises one clock after that. The early busy lets the host memory controller insert wait states before the memory is actually taken away.

In slave mode the interval timer is stopped. Each falling edge on an active-low demand input starts a strobe at once, with no lead time. Busy stays inactive in this mode. In both modes a one-clock scrub-start pulse marks the first clock of the strobe, and the memory array uses it to launch the read-correct-write of one word.

The time base is one clock. The period code is sampled only at interval boundaries. The lead code is sampled when a handshake begins.

Top module: `scrub_sched`

## Requirements
- R1: While reset is asserted, and until the first handshake, busy_n and scrub_n are 1 and scrub_start is 0.
- R2: In master mode, consecutive busy_n falling edges are `2^n + 4` clocks apart, with n the period code. This holds whenever the handshake fits inside the interval.
- R3: Period codes 0, 1 and 2 behave exactly like code 3, giving an interval of 12 clocks.
- R4: The first interval after reset uses period code 7, so busy_n first falls 132 clocks after reset, whatever the period code input is. The lead code input is 4 bits, and 10 is its reset-time setting in the bench.
- R5: In master mode scrub_n falls L clocks after busy_n falls, with L the lead code sampled when busy_n falls. For L = 0 both fall in the same clock, and scrub_n is never low while busy_n is high.
- R6: scrub_n stays low for exactly 4 clocks per strobe. scrub_start is 1 only in the first of those clocks.
- R7: In master mode busy_n rises exactly 1 clock after scrub_n rises.
- R8: A period code changed partway through an interval does not affect that interval. It sets the length of the next interval.
- R9: If the interval expires while a handshake is in progress, the request is held. busy_n then falls again 1 clock after it has risen.
- R10: In slave mode a falling edge of demand_n starts a strobe on the next clock edge, and busy_n stays 1 throughout.
- R11: In slave mode, demand_n held low gives only one strobe. A falling edge that arrives while a strobe or its tail is in progress is ignored.
- R12: In master mode demand_n has no effect, and no strobe appears outside the timed schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is the scheduler time unit |
| rst_n | input | 1 | Synchronous reset, active low |
| slave_mode | input | 1 | 0 = timed master schedule, 1 = demand-driven slave |
| period_code | input | 4 | Interval exponent n; interval = 2^n + 4 clocks, codes below 3 read as 3 |
| lead_code | input | 4 | Clocks from busy falling to scrub strobe falling |
| demand_n | input | 1 | Active-low scrub demand, used in slave mode only |
| busy_n | output | 1 | Active-low wait-state request to the host |
| scrub_n | output | 1 | Active-low scrub strobe |
| scrub_start | output | 1 | One-clock pulse on the first strobe clock, to the memory |

## Verification
The bench sets a period code during reset that differs from the default. A design that loaded the input straight away, instead of using code 7, would strobe at the wrong time. It changes the period code in the middle of an interval. An early reload would shift the very next handshake and not the one after it. Codes 0 and 1 are driven to show that the floor is applied; a missing clamp gives 5- or 6-clock intervals. A lead of 0 checks that both outputs fall together. A lead of 15 against a 12-clock interval forces overlap: a design that dropped the held request, or restarted the timer, would leave a gap longer than one clock. In slave mode a long demand pulse and a demand edge that arrives during a strobe check for repeated strobes. A demand pulse in master mode must produce no strobe at all.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_LEAD   = 2'd1,
    SC_STROBE = 2'd2,
    SC_TAIL   = 2'd3
  } sc_state_e;

  // Interval length in clocks for a period code, with reserved low codes clamped.
  function automatic int unsigned period_len(int unsigned code,
                                             int unsigned min_code,
                                             int unsigned overhead);
    int unsigned e;
    e = (code < min_code) ? min_code : code;
    return (32'd1 << e) + overhead;
  endfunction

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scrub_period_timer.sv
module scrub_period_timer import scrub_pkg::*; #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MIN_CODE = 3,
  parameter int unsigned OVERHEAD = 4,
  parameter int unsigned DEF_CODE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              expire
);
  localparam int unsigned MAX_LEN = period_len((2**CODE_W) - 1, MIN_CODE, OVERHEAD);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned DEF_LEN = period_len(DEF_CODE, MIN_CODE, OVERHEAD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_q;   // length of the interval in progress

  assign expire = en && (cnt == len_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      len_q <= CNT_W'(DEF_LEN);
    end else if (!en) begin
      cnt   <= '0;
    end else if (expire) begin
      cnt   <= '0;
      len_q <= CNT_W'(period_len(code, MIN_CODE, OVERHEAD));
    end else begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/scrub_demand_edge.sv
module scrub_demand_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic demand_n,
  output logic fall
);
  logic dmd_q;

  assign fall = dmd_q & ~demand_n;

  always_ff @(posedge clk) begin
    if (!rst_n) dmd_q <= 1'b1;
    else        dmd_q <= demand_n;
  end

endmodule

// File: rtl/scrub_handshake_fsm.sv
module scrub_handshake_fsm import scrub_pkg::*; #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned STROBE_W = 4,
  parameter int unsigned TAIL_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              expire,
  input  logic              dmd_fall,
  input  logic [CODE_W-1:0] lead_code,
  output logic              idle,
  output logic              strobe,
  output logic              strobe_first,
  output logic              pend
);
  localparam int unsigned CW = $clog2(max_of(max_of(2**CODE_W, STROBE_W), TAIL_W) + 1);

  sc_state_e         state;
  logic [CW-1:0]     cnt;
  logic [CODE_W-1:0] lead_q;
  logic              go_m;
  logic              go_s;

  assign idle         = (state == SC_IDLE);
  assign strobe       = (state == SC_STROBE);
  assign strobe_first = strobe && (cnt == '0);
  assign go_m         = idle && !slave_mode && (expire || pend);
  assign go_s         = idle && slave_mode && dmd_fall;

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (slave_mode)         pend <= 1'b0;
    else if (expire && !idle)    pend <= 1'b1;
    else if (go_m)               pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SC_IDLE;
      cnt    <= '0;
      lead_q <= '0;
    end else begin
      unique case (state)
        SC_IDLE: begin
          cnt <= '0;
          if (go_m) begin
            lead_q <= lead_code;
            state  <= (lead_code == '0) ? SC_STROBE : SC_LEAD;
          end else if (go_s) begin
            state  <= SC_STROBE;
          end
        end
        SC_LEAD: begin
          if (cnt == CW'(lead_q) - CW'(1)) begin
            cnt   <= '0;
            state <= SC_STROBE;
          end else begin
            cnt   <= cnt + CW'(1);
          end
        end
        SC_STROBE: begin
          if (cnt == CW'(STROBE_W - 1)) begin
            cnt   <= '0;
            state <= SC_TAIL;
          end else begin
            cnt   <= cnt + CW'(1);
          end
        end
        SC_TAIL: begin
          if (cnt == CW'(TAIL_W - 1)) begin
            cnt   <= '0;
            state <= SC_IDLE;
          end else begin
            cnt   <= cnt + CW'(1);
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scrub_sched.sv
module scrub_sched #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MIN_CODE = 3,
  parameter int unsigned OVERHEAD = 4,
  parameter int unsigned DEF_CODE = 7,
  parameter int unsigned STROBE_W = 4,
  parameter int unsigned TAIL_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic [CODE_W-1:0] period_code,
  input  logic [CODE_W-1:0] lead_code,
  input  logic              demand_n,
  output logic              busy_n,
  output logic              scrub_n,
  output logic              scrub_start
);
  // Named internal events, also observed by the bound checker.
  logic tmr_expire;
  logic dmd_fall;
  logic fsm_idle;
  logic fsm_strobe;
  logic fsm_first;
  logic fsm_pend;

  scrub_period_timer #(
    .CODE_W(CODE_W), .MIN_CODE(MIN_CODE), .OVERHEAD(OVERHEAD), .DEF_CODE(DEF_CODE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .en(!slave_mode), .code(period_code), .expire(tmr_expire)
  );

  scrub_demand_edge u_edge (
    .clk(clk), .rst_n(rst_n), .demand_n(demand_n), .fall(dmd_fall)
  );

  scrub_handshake_fsm #(
    .CODE_W(CODE_W), .STROBE_W(STROBE_W), .TAIL_W(TAIL_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .expire(tmr_expire),
    .dmd_fall(dmd_fall), .lead_code(lead_code), .idle(fsm_idle),
    .strobe(fsm_strobe), .strobe_first(fsm_first), .pend(fsm_pend)
  );

  assign busy_n      = ~(~fsm_idle & ~slave_mode);
  assign scrub_n     = ~fsm_strobe;
  assign scrub_start = fsm_first;

endmodule

// File: rtl/scrub_sched_chk.sv
module scrub_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_mode,
  input logic busy_n,
  input logic scrub_n,
  input logic scrub_start,
  input logic expire,
  input logic idle,
  input logic pend
);
  AST_START_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_start |-> (!scrub_n && $past(scrub_n))); // R6
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_start |=> !scrub_start); // R6
  AST_BUSY_COVERS_SCRUB: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !scrub_n) |-> !busy_n); // R5
  AST_BUSY_AFTER_SCRUB: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scrub_n) && !slave_mode) |-> !busy_n); // R7
  AST_HELD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !idle) |=> pend); // R9
  AST_BARE_STROBE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scrub_n) && $past(busy_n) && busy_n) |-> slave_mode); // R12
endmodule

bind scrub_sched scrub_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .busy_n(busy_n),
  .scrub_n(scrub_n), .scrub_start(scrub_start), .expire(tmr_expire),
  .idle(fsm_idle), .pend(fsm_pend)
);

// File: tb/test_scrub_sched.sv
`timescale 1ns/1ps
module test_scrub_sched;
  typedef struct {
    int    tb;   // expected busy fall cycle, -1 when busy must stay high
    int    ts;   // expected scrub fall cycle
    string req;
  } evt_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slave_mode = 1'b0;
  logic [3:0] period_code = 4'd4;
  logic [3:0] lead_code = 4'd10;
  logic       demand_n = 1'b1;
  logic       busy_n, scrub_n, scrub_start;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  int   events = 0;
  evt_t exp_q[$];

  always #4 clk = ~clk;

  scrub_sched i_scrub_sched (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .period_code(period_code),
    .lead_code(lead_code), .demand_n(demand_n), .busy_n(busy_n),
    .scrub_n(scrub_n), .scrub_start(scrub_start)
  );

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(bit ok, string r, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", r, cyc, act, expv);
    end
  endtask

  function automatic int plen(int code);
    int e = (code < 3) ? 3 : code;
    return (1 << e) + 4;
  endfunction

  task automatic push(int tb, int ts, string r);
    evt_t e;
    e.tb = tb; e.ts = ts; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic at(int n);
    wait (cyc >= n);
    @(negedge clk);
  endtask

  // Monitor: compares observed edges with the scoreboard.
  logic prev_b = 1'b1, prev_s = 1'b1;
  int   last_bf = -100, last_sf = -100, last_sr = -100;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_b && !busy_n) begin
        last_bf = cyc;
        if (slave_mode) chk(1'b0, "R10 busy fell in slave mode", 0, 1);
      end
      if (prev_s && !scrub_n) begin
        events++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12 unexpected strobe", cyc, -1);
        end else begin
          evt_t e;
          e = exp_q.pop_front();
          chk(cyc == e.ts, {e.req, " scrub fall time"}, cyc, e.ts);
          if (e.tb >= 0) chk(last_bf == e.tb, {e.req, " busy fall time"}, last_bf, e.tb);
          else           chk(busy_n == 1'b1, "R10 busy stays high", busy_n, 1);
        end
        chk(scrub_start == 1'b1, "R6 start pulse on first strobe clock", scrub_start, 1);
        last_sf = cyc;
      end else if (scrub_start) begin
        chk(1'b0, "R6 start pulse outside strobe start", 1, 0);
      end
      if (!prev_s && scrub_n) begin
        chk(cyc - last_sf == 4, "R6 strobe width", cyc - last_sf, 4);
        last_sr = cyc;
      end
      if (!prev_b && busy_n)
        chk(cyc - last_sr == 1, "R7 busy release delay", cyc - last_sr, 1);
      prev_b = busy_n;
      prev_s = scrub_n;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3, t4, t5, t6, t7, t8, t9, t10, t11, hs;
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1 && scrub_n == 1'b1, "R1 idle outputs in reset", {busy_n, scrub_n}, 3);
    chk(scrub_start == 1'b0, "R1 no start in reset", scrub_start, 0);
    rst_n = 1'b1;

    // Default interval first, then the input code 4 from the first boundary.
    t0 = plen(7);        push(t0, t0 + 10, "R4");
    t1 = t0 + plen(4);   push(t1, t1 + 10, "R2");
    t2 = t1 + plen(4);   push(t2, t2 + 10, "R2");
    at(10);
    chk(busy_n == 1'b1 && scrub_n == 1'b1, "R1 idle after reset", {busy_n, scrub_n}, 3);

    // Change mid-interval: the running interval keeps code 4.
    at(175); period_code = 4'd5; lead_code = 4'd2;
    t3 = t2 + plen(4);   push(t3, t3 + 2, "R8");
    t4 = t3 + plen(5);   push(t4, t4 + 2, "R8");
    t5 = t4 + plen(5);   push(t5, t5 + 2, "R5");

    // Reserved code and zero lead.
    at(270); period_code = 4'd1; lead_code = 4'd0;
    t6 = t5 + plen(5);   push(t6, t6, "R5");
    t7 = t6 + plen(1);   push(t7, t7, "R3");
    t8 = t7 + plen(0);   push(t8, t8, "R3");

    // Handshake longer than the interval: held request.
    at(326); lead_code = 4'd15;
    hs = 15 + 4 + 1;
    t9  = t8 + plen(1);  push(t9, t9 + 15, "R5");
    t10 = t9 + hs + 1;   push(t10, t10 + 15, "R9");
    at(358); period_code = 4'd15; lead_code = 4'd0;
    t11 = t10 + hs + 1;  push(t11, t11, "R9");

    // Demand in master mode is ignored.
    at(390); demand_n = 1'b0;
    at(393); demand_n = 1'b1;
    at(400);
    chk(events == 12, "R12 strobe count in master mode", events, 12);
    slave_mode = 1'b1;

    // Slave demands.
    at(410); demand_n = 1'b0; push(-1, 411, "R10");
    at(416); demand_n = 1'b1;
    at(430); demand_n = 1'b0; push(-1, 431, "R11");
    at(442); demand_n = 1'b1;
    at(460); demand_n = 1'b0; push(-1, 461, "R11");
    at(462); demand_n = 1'b1;
    at(463); demand_n = 1'b0;
    at(470); demand_n = 1'b1;
    at(500);
    chk(exp_q.size() == 0, "R11 all expected strobes seen", exp_q.size(), 0);
    chk(events == 15, "R11 no extra strobes", events, 15);
    finish_run();
  end
endmodule